// File: doc/BRIEF.md
# Register-Mapped GPIO Controller with Per-Pin Interrupts

This block gives a processor a configurable number of general-purpose pins (fewer than 32) behind a small 32-bit register bus. Software sets each pin's direction, drives outputs by writing ones to a set word or a clear word, and reads the pin levels after a two-flop synchronizer. It never has to read, modify and write the output word.

Each pin can raise an interrupt. A type bit chooses level or edge sensing, and a polarity bit chooses high/rising or low/falling. An enable bit qualifies the capture of causes. Causes collect in a pending word. A mask bit gates pending causes onto one registered, active-high interrupt line. Software can build dual-edge detection by rewriting the polarity bit after each event, because a new polarity is used from the next cycle on. A build-time parameter inverts the meaning of the direction word.

The bus address is a byte address. Only word-aligned addresses (low two bits zero) are decoded. Any other address reads zero, and a write to it has no effect.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset all pins are inputs (`pinOutEn` zero), `pinOut` is zero, `irqOut` is low, and every register reads zero, except the direction word in the inverted variant.
- R2: Direction word at byte offset 0x00, one bit per pin. With `OE_INVERT`=0, a 1 drives `pinOutEn` high for that pin. With `OE_INVERT`=1, a 1 makes the pin an input, and the word resets to all ones for the implemented pins.
- R3: A write to 0x0C sets to 1 every output bit whose data bit is 1. A write to 0x10 clears to 0 every output bit whose data bit is 1. Zero data bits leave outputs unchanged. Reading 0x0C returns the output word, and reading 0x10 returns zero.
- R4: Offset 0x04 returns the pin levels through a two-flop synchronizer. A pin change made between two clock edges reads back after the second following rising edge. Writes to 0x04 have no effect.
- R5: Edge mode (type bit 0): a rising edge (polarity 1) or a falling edge (polarity 0) on the synchronized input sets that pin's pending bit, but only if its enable bit is 1. The bit is set on the third rising edge after the pin changes. It stays set until a write of 1 to that bit at 0x20.
- R6: Level mode (type bit 1): the pending bit is 1 exactly when the enable bit is 1 and the synchronized level equals the polarity bit. It is updated every cycle, and writes to 0x20 do not change it.
- R7: `irqOut` is registered. It equals the OR over all pins of pending AND enable AND mask from the previous cycle.
- R8: A polarity change takes effect from the next cycle. Inverting the polarity while the input is steady creates no event, and the next opposite edge is then captured.
- R9: Register bits at or above `PIN_COUNT` read as zero, and writing them has no effect.
- R10: Word map, as byte offsets: direction 0x00, input 0x04, set 0x0C, clear 0x10, enable 0x14, type 0x18, polarity 0x1C, pending 0x20, mask 0x24. Any other address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Write strobe for the addressed word |
| busAddr | input | 6 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| pinIn | input | PIN_COUNT | Pin levels from the pads, asynchronous |
| pinOut | output | PIN_COUNT | Output levels to the pads |
| pinOutEn | output | PIN_COUNT | Per-pin drive enable, 1 = drive |
| irqOut | output | 1 | Combined interrupt, registered, active high |

## Verification
The properties assume that `busWe`, `busAddr` and `busWdata` are stable around each rising edge and that a write lasts exactly one cycle. The stimulus meets this by changing them only on falling edges. The checks on pending bits assume that type and enable move only through bus writes, so a new pending bit can always be traced to the previous cycle's configuration. The bench changes pins only on falling edges and waits at least three edges before it expects a pending change. This keeps synchronizer latency out of the comparisons. Dual-edge operation is exercised the way software would do it: it rewrites the polarity while the input is held steady.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // word indices (byte address bits [5:2])
  localparam logic [3:0] WORD_DIR  = 4'd0;
  localparam logic [3:0] WORD_IN   = 4'd1;
  localparam logic [3:0] WORD_SET  = 4'd3;
  localparam logic [3:0] WORD_CLR  = 4'd4;
  localparam logic [3:0] WORD_EN   = 4'd5;
  localparam logic [3:0] WORD_TYPE = 4'd6;
  localparam logic [3:0] WORD_POL  = 4'd7;
  localparam logic [3:0] WORD_PEND = 4'd8;
  localparam logic [3:0] WORD_MASK = 4'd9;

  typedef struct packed {
    logic wrDir;
    logic wrSet;
    logic wrClr;
    logic wrEn;
    logic wrType;
    logic wrPol;
    logic wrPendAck;
    logic wrMask;
  } gpioStrobes_t;

  typedef enum logic [3:0] {
    RD_ZERO, RD_DIR, RD_IN, RD_OUT, RD_EN, RD_TYPE, RD_POL, RD_PEND, RD_MASK
  } readSel_t;

endpackage

// File: rtl/gpio_irq_decode.sv
module gpio_irq_decode
  import gpio_irq_pkg::*;
(
  input  logic         busWe,
  input  logic [5:0]   busAddr,
  output gpioStrobes_t strobes,
  output readSel_t     readSel
);

  logic aligned;
  assign aligned = (busAddr[1:0] == 2'b00);

  always_comb begin
    strobes = '0;
    readSel = RD_ZERO;
    if (aligned) begin
      case (busAddr[5:2])
        WORD_DIR:  begin strobes.wrDir     = busWe; readSel = RD_DIR;  end
        WORD_IN:   begin                            readSel = RD_IN;   end
        WORD_SET:  begin strobes.wrSet     = busWe; readSel = RD_OUT;  end
        WORD_CLR:  begin strobes.wrClr     = busWe; readSel = RD_ZERO; end
        WORD_EN:   begin strobes.wrEn      = busWe; readSel = RD_EN;   end
        WORD_TYPE: begin strobes.wrType    = busWe; readSel = RD_TYPE; end
        WORD_POL:  begin strobes.wrPol     = busWe; readSel = RD_POL;  end
        WORD_PEND: begin strobes.wrPendAck = busWe; readSel = RD_PEND; end
        WORD_MASK: begin strobes.wrMask    = busWe; readSel = RD_MASK; end
        default:   begin                            readSel = RD_ZERO; end
      endcase
    end
  end

endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int PIN_COUNT = 16,
  parameter bit OE_INVERT = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  gpioStrobes_t         strobes,
  input  readSel_t             readSel,
  input  logic [PIN_COUNT-1:0] wrData,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [31:0]          busRdata,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOutEn,
  output logic                 irqOut,
  output logic [PIN_COUNT-1:0] typeVec,
  output logic [PIN_COUNT-1:0] polVec,
  output logic [PIN_COUNT-1:0] enVec,
  output logic [PIN_COUNT-1:0] maskVec,
  output logic [PIN_COUNT-1:0] pendVec
);

  localparam int PAD_W = 32 - PIN_COUNT;
  localparam logic [PIN_COUNT-1:0] DIR_RESET = OE_INVERT ? '1 : '0;

  logic [PIN_COUNT-1:0] dirReg;
  logic [PIN_COUNT-1:0] syncA, syncB, prevLvl;
  logic [PIN_COUNT-1:0] pendNext;

  // configuration words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirReg  <= DIR_RESET;
      pinOut  <= '0;
      enVec   <= '0;
      typeVec <= '0;
      polVec  <= '0;
      maskVec <= '0;
    end else begin
      if (strobes.wrDir)  dirReg  <= wrData;
      if (strobes.wrSet)  pinOut  <= pinOut | wrData;
      if (strobes.wrClr)  pinOut  <= pinOut & ~wrData;
      if (strobes.wrEn)   enVec   <= wrData;
      if (strobes.wrType) typeVec <= wrData;
      if (strobes.wrPol)  polVec  <= wrData;
      if (strobes.wrMask) maskVec <= wrData;
    end
  end

  assign pinOutEn = OE_INVERT ? ~dirReg : dirReg;

  // two-flop synchronizer plus a history stage for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncA   <= '0;
      syncB   <= '0;
      prevLvl <= '0;
    end else begin
      syncA   <= pinIn;
      syncB   <= syncA;
      prevLvl <= syncB;
    end
  end

  // per-pin cause capture
  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    logic levelHit, edgeHit, ackBit;
    assign levelHit = (syncB[p] == polVec[p]);
    assign edgeHit  = (syncB[p] != prevLvl[p]) && levelHit;
    assign ackBit   = strobes.wrPendAck && wrData[p];
    always_comb begin
      if (typeVec[p]) pendNext[p] = enVec[p] && levelHit;
      else            pendNext[p] = (pendVec[p] && !ackBit) || (enVec[p] && edgeHit);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendVec <= '0;
      irqOut  <= 1'b0;
    end else begin
      pendVec <= pendNext;
      irqOut  <= |(pendVec & enVec & maskVec);
    end
  end

  // read mux, zero-extended above the implemented pins
  logic [PIN_COUNT-1:0] rdPins;
  always_comb begin
    case (readSel)
      RD_DIR:  rdPins = dirReg;
      RD_IN:   rdPins = syncB;
      RD_OUT:  rdPins = pinOut;
      RD_EN:   rdPins = enVec;
      RD_TYPE: rdPins = typeVec;
      RD_POL:  rdPins = polVec;
      RD_PEND: rdPins = pendVec;
      RD_MASK: rdPins = maskVec;
      default: rdPins = '0;
    endcase
  end
  assign busRdata = {{PAD_W{1'b0}}, rdPins};

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int PIN_COUNT = 16,
  parameter bit OE_INVERT = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 busWe,
  input  logic [5:0]           busAddr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOutEn,
  output logic                 irqOut
);

  gpioStrobes_t         strobes;
  readSel_t             readSel;
  logic [PIN_COUNT-1:0] typeVec, polVec, enVec, maskVec, pendVec;
  logic                 unusedWdataHi;

  assign unusedWdataHi = &{1'b0, busWdata[31:PIN_COUNT]};

  gpio_irq_decode u_decode (
    .busWe   (busWe),
    .busAddr (busAddr),
    .strobes (strobes),
    .readSel (readSel)
  );

  gpio_irq_datapath #(.PIN_COUNT(PIN_COUNT), .OE_INVERT(OE_INVERT)) u_datapath (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .readSel  (readSel),
    .wrData   (busWdata[PIN_COUNT-1:0]),
    .pinIn    (pinIn),
    .busRdata (busRdata),
    .pinOut   (pinOut),
    .pinOutEn (pinOutEn),
    .irqOut   (irqOut),
    .typeVec  (typeVec),
    .polVec   (polVec),
    .enVec    (enVec),
    .maskVec  (maskVec),
    .pendVec  (pendVec)
  );

endmodule

// File: rtl/gpio_irq_checker.sv
module gpio_irq_checker #(
  parameter int PIN_COUNT = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 busWe,
  input logic [5:0]           busAddr,
  input logic [PIN_COUNT-1:0] wrPins,
  input logic [PIN_COUNT-1:0] pinOut,
  input logic                 irqOut,
  input logic [PIN_COUNT-1:0] typeVec,
  input logic [PIN_COUNT-1:0] enVec,
  input logic [PIN_COUNT-1:0] maskVec,
  input logic [PIN_COUNT-1:0] pendVec
);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pinOut == '0 && !irqOut));

  assert_set_drives_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busWe && busAddr == 6'h0C) |=> ((pinOut & $past(wrPins)) == $past(wrPins)));

  assert_clear_drives_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busWe && busAddr == 6'h10) |=> ((pinOut & $past(wrPins)) == '0));

  assert_edge_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pendVec & ~$past(pendVec) & ~$past(typeVec) & ~$past(enVec)) == '0);

  assert_level_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pendVec & $past(typeVec) & ~$past(enVec)) == '0);

  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (irqOut == |($past(pendVec & enVec & maskVec))));

endmodule

bind gpio_irq_ctrl gpio_irq_checker #(.PIN_COUNT(PIN_COUNT)) u_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .busWe   (busWe),
  .busAddr (busAddr),
  .wrPins  (busWdata[PIN_COUNT-1:0]),
  .pinOut  (pinOut),
  .irqOut  (irqOut),
  .typeVec (typeVec),
  .enVec   (enVec),
  .maskVec (maskVec),
  .pendVec (pendVec)
);

// File: tb/test_gpio_irq_ctrl.sv
module test_gpio_irq_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NPINS = 16;

  localparam logic [5:0] A_DIR = 6'h00, A_IN = 6'h04, A_SET = 6'h0C, A_CLR = 6'h10,
                         A_EN = 6'h14, A_TYPE = 6'h18, A_POL = 6'h1C, A_PEND = 6'h20,
                         A_MASK = 6'h24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic busWe = 1'b0;
  logic [5:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [NPINS-1:0] pinIn = '0;
  logic [NPINS-1:0] pinOut, pinOutEn;
  logic irqOut;

  logic invWe = 1'b0;
  logic [5:0] invAddr = '0;
  logic [31:0] invWdata = '0;
  logic [31:0] invRdata;
  logic [7:0] invOut, invOutEn;
  logic invIrq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  gpio_irq_ctrl #(.PIN_COUNT(NPINS), .OE_INVERT(1'b0)) i_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .pinIn(pinIn), .pinOut(pinOut), .pinOutEn(pinOutEn), .irqOut(irqOut)
  );

  gpio_irq_ctrl #(.PIN_COUNT(8), .OE_INVERT(1'b1)) i_gpio_irq_ctrl_inv (
    .clk(clk), .rst_n(rst_n), .busWe(invWe), .busAddr(invAddr), .busWdata(invWdata),
    .busRdata(invRdata), .pinIn(8'h00), .pinOut(invOut), .pinOutEn(invOutEn), .irqOut(invIrq)
  );

  typedef struct packed {
    logic [5:0]  wAddr;
    logic [31:0] wData;
    logic [5:0]  rAddr;
    logic [31:0] rExp;
  } vecT;

  localparam vecT VECS [10] = '{
    '{A_DIR,  32'hFFFF00F0, A_DIR,  32'h000000F0},  // R2 R9
    '{A_SET,  32'h000000FF, A_SET,  32'h000000FF},  // R3
    '{A_CLR,  32'h0000000F, A_SET,  32'h000000F0},  // R3
    '{A_SET,  32'h00010000, A_SET,  32'h000000F0},  // R9
    '{A_CLR,  32'h00000000, A_CLR,  32'h00000000},  // R3
    '{A_MASK, 32'h00001234, A_MASK, 32'h00001234},  // R10
    '{A_TYPE, 32'hFFFF0000, A_TYPE, 32'h00000000},  // R9
    '{A_POL,  32'h00008001, A_POL,  32'h00008001},  // R10
    '{A_IN,   32'h0000FFFF, A_IN,   32'h00000000},  // R4
    '{6'h0E,  32'h0000FFFF, A_SET,  32'h000000F0}   // R10 unaligned write ignored
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic setPins(input logic [NPINS-1:0] v);
    @(negedge clk);
    pinIn = v;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 pinOut", 32'(pinOut), 32'h0);
    check("R1 pinOutEn", 32'(pinOutEn), 32'h0);
    check("R1 irqOut", 32'(irqOut), 32'h0);
    for (int k = 0; k < 10; k++) begin
      rd(6'(k * 4), r);
      check("R1 register reset", r, 32'h0);
    end
    check("R1 inverted pinOutEn", 32'(invOutEn), 32'h0);
    invAddr = A_DIR; #1;
    check("R2 inverted dir reset", invRdata, 32'h000000FF);

    // table walk
    for (int i = 0; i < 10; i++) begin
      wr(VECS[i].wAddr, VECS[i].wData);
      rd(VECS[i].rAddr, r);
      if (r !== VECS[i].rExp) $display("  table entry %0d", i);
      check("R10 table", r, VECS[i].rExp);
    end
    check("R3 pinOut", 32'(pinOut), 32'h000000F0);
    check("R2 pinOutEn", 32'(pinOutEn), 32'h000000F0);

    // R2 inverted sense
    @(negedge clk); invWe = 1'b1; invAddr = A_DIR; invWdata = 32'hFFFFFF0F;
    @(negedge clk); invWe = 1'b0; #1;
    check("R2 inverted pinOutEn", 32'(invOutEn), 32'h000000F0);
    check("R9 inverted dir readback", invRdata, 32'h0000000F);

    // R4 synchronizer latency
    setPins(16'h0005);
    rd(A_IN, r); check("R4 zero edges", r, 32'h0);
    @(negedge clk); rd(A_IN, r); check("R4 one edge", r, 32'h0);
    @(negedge clk); rd(A_IN, r); check("R4 two edges", r, 32'h5);
    setPins(16'h0000);
    repeat (4) @(negedge clk);

    // R5 edge mode, rising on pin0
    wr(A_POL, 32'h1); wr(A_TYPE, 32'h0); wr(A_MASK, 32'h1); wr(A_EN, 32'h1);
    wr(A_PEND, 32'hFFFF);
    setPins(16'h0001);
    @(negedge clk); @(negedge clk);
    rd(A_PEND, r); check("R5 not yet pending", r, 32'h0);
    @(negedge clk); rd(A_PEND, r); check("R5 rising pending", r, 32'h1);
    check("R7 irq lags pending", 32'(irqOut), 32'h0);
    @(negedge clk); check("R7 irq asserted", 32'(irqOut), 32'h1);
    setPins(16'h0000);
    repeat (4) @(negedge clk);
    rd(A_PEND, r); check("R5 sticky", r, 32'h1);
    wr(A_PEND, 32'h1);
    rd(A_PEND, r); check("R5 ack clears", r, 32'h0);
    check("R7 irq one cycle late", 32'(irqOut), 32'h1);
    @(negedge clk); check("R7 irq dropped", 32'(irqOut), 32'h0);

    // R5 enable gating, falling on pin2
    setPins(16'h0004); repeat (4) @(negedge clk);
    setPins(16'h0000); repeat (4) @(negedge clk);
    rd(A_PEND, r); check("R5 disabled edge ignored", r, 32'h0);
    wr(A_EN, 32'h5);
    setPins(16'h0004); repeat (4) @(negedge clk);
    rd(A_PEND, r); check("R5 rising ignored for falling", r, 32'h0);
    setPins(16'h0000); repeat (4) @(negedge clk);
    rd(A_PEND, r); check("R5 falling pending", r, 32'h4);
    check("R7 masked", 32'(irqOut), 32'h0);
    wr(A_MASK, 32'h5);
    check("R7 before unmask seen", 32'(irqOut), 32'h0);
    @(negedge clk); check("R7 unmasked", 32'(irqOut), 32'h1);
    wr(A_PEND, 32'h4);
    repeat (2) @(negedge clk);
    check("R7 cleared", 32'(irqOut), 32'h0);

    // R6 level mode on pin3
    wr(A_TYPE, 32'h8); wr(A_POL, 32'h9); wr(A_EN, 32'hD);
    setPins(16'h0008); repeat (3) @(negedge clk);
    rd(A_PEND, r); check("R6 high level", r, 32'h8);
    wr(A_PEND, 32'h8);
    rd(A_PEND, r); check("R6 ack ignored", r, 32'h8);
    setPins(16'h0000); repeat (3) @(negedge clk);
    rd(A_PEND, r); check("R6 level gone", r, 32'h0);
    wr(A_POL, 32'h1);
    @(negedge clk); rd(A_PEND, r); check("R6 low level", r, 32'h8);
    wr(A_EN, 32'h5);
    @(negedge clk); rd(A_PEND, r); check("R6 disabled", r, 32'h0);
    wr(A_TYPE, 32'h0);

    // R8 emulated dual edge on pin4
    wr(A_POL, 32'h11); wr(A_EN, 32'h15);
    setPins(16'h0010); repeat (3) @(negedge clk);
    rd(A_PEND, r); check("R8 rising", r, 32'h10);
    wr(A_PEND, 32'h10); wr(A_POL, 32'h01);
    repeat (4) @(negedge clk);
    rd(A_PEND, r); check("R8 no spurious event", r, 32'h0);
    setPins(16'h0000); repeat (3) @(negedge clk);
    rd(A_PEND, r); check("R8 falling after flip", r, 32'h10);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule